// File: doc/BRIEF.md
# Dual-Bank NOR Flash Command Decoder

This block is the command front end of a word-wide NOR flash with two banks. It watches host write cycles (address, data, write strobe), recognises the two-write unlock preamble and the command that follows, and keeps a separate mode for each bank. Two command sequences are decoded: word program and identification (autoselect). A reset command ends an autoselect session, clears a failed program and aborts a half-written sequence. A small register array stands in for the cells. The embedded program operation is a counter of fixed length that then merges the new word into the array.

Reads are registered. A read returns the array word, an identification code or a status word, depending on the mode of the bank it addresses. The top address bit selects the bank, the low five bits select one of 32 words in that bank, and word bit 4 picks one of two 16-word sectors per bank. An external erase engine reports through `erase_act` whether either bank is actively erasing. A bank whose erase is suspended shows that input low and behaves as a read-mode bank.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset every array word reads FFFFh, `busy` is low and both banks are in read mode.
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h, then (address, data) starts a program of that word. The command byte is data[7:0], the unlock match uses address[10:0], and `busy` rises after the fourth write. When `busy` falls, reads of that word return the merged value.
- R3: `busy` stays high for exactly PROG_CYC clock cycles. While it is high, every write is ignored, including reset and whole command sequences aimed at either bank.
- R4: The stored word becomes old AND written data. If the written data has a 1 where the old word has a 0, the bank enters an error state after the busy period. In that state its reads return status with bit 5 set until a reset command (low byte F0h) to that bank returns it to read mode.
- R5: Reads from a bank that is programming or in error return a status word. Bit 7 is the complement of written-data bit 7. Bit 6 is 0 on the first read after the program starts and inverts on every following read. Bit 5 is the error flag. All other bits are 0. The other bank keeps returning array data.
- R6: A reset write (F0h) after the first or the second unlock write returns the sequence to idle, and the writes that follow do not program anything.
- R7: Once A0h has been accepted as the third write, the next write is program data even if its low byte is F0h.
- R8: Any write that does not match the expected unlock or command cycle returns the sequence to idle without effect.
- R9: AAh@555h, 55h@2AAh, 90h@555h with the top address bit naming the bank puts that bank in autoselect. The read value depends on address[3:0]. Offset 0h returns 0001h and offsets 1h, Eh, Fh return 227Eh, 2204h, 2201h. Offset 2h returns 0001h if the addressed sector is locked and 0000h otherwise; by default only bank 1 sector 0 is locked. Other offsets return 0000h. Codes can be read any number of times.
- R10: An autoselect or program command is refused if the target bank is not in read mode (autoselect or error) or if either bit of `erase_act` is high.
- R11: Only a reset write addressed to the bank leaves autoselect, returning it to read mode. Program sequences and other writes leave it in autoselect, and the other bank keeps reading array data.
- R12: Programs may target any word in any order, across sector and bank boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe, one write per cycle it is high |
| rd | input | 1 | Read strobe, data appears on `rdata` after the edge |
| addr | input | ADDR_W | Word address; top bit selects the bank |
| wdata | input | 16 | Write data; command byte in bits 7:0 |
| erase_act | input | 2 | Per-bank erase-in-progress indication from the erase engine |
| rdata | output | 16 | Registered read data |
| busy | output | 1 | High while the embedded program runs |

## Verification
The bench targets the stage at which a reset arrives. A decoder that treated F0h as reset after the set-up write would lose a legitimate program, and one that let reset through during the busy window would drop a program or corrupt the sequence state. It writes 0-to-1 patterns over programmed words. An OR merge, or a missing error flag, shows up as a wrong word or as array data where status was expected. It also sends commands to a bank in autoselect or error and while an erase is reported. A decoder that checked the wrong bank, or ignored the erase input, would enter autoselect or start a program where it must refuse.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int          ADDR_W    = 12,
  parameter int          WORDS_LOG = 5,
  parameter int          SECT_LOG  = 4,
  parameter int          PROG_CYC  = 16,
  parameter logic [63:0] LOCK_MAP  = 64'h4,
  parameter logic [15:0] ID_MFR    = 16'h0001,
  parameter logic [15:0] ID_W1     = 16'h227E,
  parameter logic [15:0] ID_W2     = 16'h2204,
  parameter logic [15:0] ID_W3     = 16'h2201
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [1:0]        erase_act,
  output logic [15:0]       rdata,
  output logic              busy
);
  localparam int NW = 2 ** (WORDS_LOG + 1);
  localparam int CW = $clog2(PROG_CYC + 1);
  localparam int SW = WORDS_LOG - SECT_LOG + 1;

  typedef enum logic [1:0] {M_READ, M_ASEL, M_PROG, M_ERR} mode_t;
  typedef enum logic [1:0] {S_IDLE, S_U1, S_U2, S_SET} stg_t;

  mode_t              mode [2];
  stg_t               stage;
  logic [15:0]        mem [NW];
  logic [CW-1:0]      cnt;
  logic [WORDS_LOG:0] p_idx;
  logic [15:0]        p_dat;
  logic               p_err;
  logic [1:0]         d7, tog;
  logic [15:0]        asel_val, rd_val;

  wire                 wb     = addr[ADDR_W-1];
  wire [WORDS_LOG:0]   idx    = {wb, addr[WORDS_LOG-1:0]};
  wire [SW-1:0]        sec    = {wb, addr[WORDS_LOG-1:SECT_LOG]};
  wire [SECT_LOG-1:0]  off    = addr[SECT_LOG-1:0];
  wire [10:0]          lo     = addr[10:0];
  wire [7:0]           cmd    = wdata[7:0];
  wire                 done   = busy && (cnt == '0);
  wire                 is_rst = (cmd == 8'hF0) && (stage != S_SET);
  wire                 pbank  = p_idx[WORDS_LOG];
  wire                 ready  = (mode[wb] == M_READ) && (erase_act == 2'b00);

  always_comb begin
    asel_val = '0;
    if (off == SECT_LOG'(0))       asel_val = ID_MFR;
    else if (off == SECT_LOG'(1))  asel_val = ID_W1;
    else if (off == SECT_LOG'(14)) asel_val = ID_W2;
    else if (off == SECT_LOG'(15)) asel_val = ID_W3;
    else if (off == SECT_LOG'(2))  asel_val = {15'd0, LOCK_MAP[sec]};
  end

  always_comb begin
    case (mode[wb])
      M_READ:  rd_val = mem[idx];
      M_ASEL:  rd_val = asel_val;
      default: rd_val = {8'h00, ~d7[wb], tog[wb], mode[wb] == M_ERR, 5'b00000};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '1;
    end else if (done) begin
      mem[p_idx] <= mem[p_idx] & p_dat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage   <= S_IDLE;
      mode[0] <= M_READ;
      mode[1] <= M_READ;
      busy    <= 1'b0;
      cnt     <= '0;
      p_idx   <= '0;
      p_dat   <= '0;
      p_err   <= 1'b0;
      d7      <= '0;
      tog     <= '0;
      rdata   <= '0;
    end else begin
      if (rd) begin
        rdata <= rd_val;
        if (mode[wb] == M_PROG || mode[wb] == M_ERR) tog[wb] <= ~tog[wb];
      end
      if (busy) begin
        if (done) begin
          busy        <= 1'b0;
          mode[pbank] <= p_err ? M_ERR : M_READ;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (we) begin
        if (is_rst) begin
          stage    <= S_IDLE;
          mode[wb] <= M_READ;
        end else begin
          stage <= S_IDLE;   // R8: any mismatch falls back to idle
          case (stage)
            S_IDLE: if (lo == 11'h555 && cmd == 8'hAA) stage <= S_U1;
            S_U1:   if (lo == 11'h2AA && cmd == 8'h55) stage <= S_U2;
            S_U2: begin
              if (lo == 11'h555 && cmd == 8'hA0) stage <= S_SET;
              else if (lo == 11'h555 && cmd == 8'h90 && ready) mode[wb] <= M_ASEL;
            end
            default: begin
              if (ready) begin
                busy     <= 1'b1;
                cnt      <= CW'(PROG_CYC - 1);
                mode[wb] <= M_PROG;
                p_idx    <= idx;
                p_dat    <= wdata;
                p_err    <= (wdata & ~mem[idx]) != '0;
                d7[wb]   <= wdata[7];
                tog[wb]  <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end

  AST_MERGE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((mem[p_idx] & ~$past(mem[p_idx])) == '0)); // R4

  AST_WRITE_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we) |=> ($stable(stage) && mode[!pbank] == $past(mode[!pbank]))); // R3

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy); // R3

  AST_BUSY_OWNS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode[pbank] == M_PROG && mode[!pbank] != M_PROG)); // R3

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && mode[wb] == M_PROG) |=> (rdata[15:8] == 8'h00 && !rdata[5])); // R5

  for (genvar g = 0; g < 2; g++) begin : g_bank_chk
    AST_ASEL_ENTRY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[g] == M_ASEL && $past(mode[g]) != M_ASEL) |->
        ($past(erase_act) == 2'b00 && $past(mode[g]) == M_READ)); // R10

    AST_ASEL_EXIT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[g] == M_ASEL && !(we && !busy && cmd == 8'hF0 && wb == g[0])) |=>
        mode[g] == M_ASEL); // R11
  end
endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;
  localparam int PROG_CYC = 16;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  erase_act = '0;
  logic [15:0] rdata;
  logic        busy;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  nor_cmd_seq #(.PROG_CYC(PROG_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .we(we), .rd(rd), .addr(addr), .wdata(wdata),
    .erase_act(erase_act), .rdata(rdata), .busy(busy));

  // behavioural reference model
  bit [15:0] mem_m [64];
  int  mode_m [2];             // 0 read, 1 autoselect, 2 programming, 3 error
  int  stage_m, cnt_m, pidx_m;
  bit [15:0] pdat_m, rdata_m;
  bit  perr_m, busy_m;
  bit  d7_m [2];
  bit  tog_m [2];

  function automatic bit [15:0] asel_code(bit [11:0] a);
    case (a[3:0])
      4'h0: return 16'h0001;
      4'h1: return 16'h227E;
      4'hE: return 16'h2204;
      4'hF: return 16'h2201;
      4'h2: return ({a[11], a[4]} == 2'b10) ? 16'h0001 : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    int b, ix;
    b  = int'(addr[11]);
    ix = int'({addr[11], addr[4:0]});
    if (!rst_n) begin
      foreach (mem_m[i]) mem_m[i] = 16'hFFFF;
      mode_m[0] = 0; mode_m[1] = 0; stage_m = 0; cnt_m = 0; busy_m = 0;
      rdata_m = 0; tog_m[0] = 0; tog_m[1] = 0; d7_m[0] = 0; d7_m[1] = 0;
    end else begin
      if (rd) begin
        if (mode_m[b] == 0) rdata_m = mem_m[ix];
        else if (mode_m[b] == 1) rdata_m = asel_code(addr);
        else begin
          rdata_m = (d7_m[b] ? 16'h0 : 16'h80) | (tog_m[b] ? 16'h40 : 16'h0) |
                    (mode_m[b] == 3 ? 16'h20 : 16'h0);
          tog_m[b] = !tog_m[b];
        end
      end
      if (busy_m) begin
        if (cnt_m == 0) begin
          mem_m[pidx_m] = mem_m[pidx_m] & pdat_m;
          mode_m[pidx_m / 32] = perr_m ? 3 : 0;
          busy_m = 0;
        end else cnt_m--;
      end else if (we) begin
        if (wdata[7:0] == 8'hF0 && stage_m != 3) begin
          stage_m = 0; mode_m[b] = 0;
        end else if (stage_m == 0) begin
          stage_m = (addr[10:0] == 11'h555 && wdata[7:0] == 8'hAA) ? 1 : 0;
        end else if (stage_m == 1) begin
          stage_m = (addr[10:0] == 11'h2AA && wdata[7:0] == 8'h55) ? 2 : 0;
        end else if (stage_m == 2) begin
          stage_m = 0;
          if (addr[10:0] == 11'h555 && wdata[7:0] == 8'hA0) stage_m = 3;
          else if (addr[10:0] == 11'h555 && wdata[7:0] == 8'h90 &&
                   mode_m[b] == 0 && erase_act == 0) mode_m[b] = 1;
        end else begin
          stage_m = 0;
          if (mode_m[b] == 0 && erase_act == 0) begin
            busy_m = 1; cnt_m = PROG_CYC - 1; mode_m[b] = 2; pidx_m = ix;
            pdat_m = wdata; perr_m = (wdata & ~mem_m[ix]) != 0;
            d7_m[b] = wdata[7]; tog_m[b] = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      checks += 2;
      if (rdata !== rdata_m) begin
        fails++; $display("FAIL R2 model rdata actual %h expected %h", rdata, rdata_m);
      end
      if (busy !== busy_m) begin
        fails++; $display("FAIL R3 model busy actual %b expected %b", busy, busy_m);
      end
    end
    if (cyc > 150000) begin
      fails++; $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++; $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ad(bit b, logic [10:0] o);
    return {b, o};
  endfunction

  task automatic wr(logic [11:0] a, logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdc(logic [11:0] a, logic [15:0] exp, string tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic unlock(bit b);
    wr(ad(b, 11'h555), 16'h00AA);
    wr(ad(b, 11'h2AA), 16'h0055);
  endtask

  task automatic prog(logic [11:0] a, logic [15:0] d);
    unlock(a[11]);
    wr(ad(a[11], 11'h555), 16'h00A0);
    wr(a, d);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {15'd0, busy}, 16'h0000);
    rdc(ad(0, 11'h000), 16'hFFFF, "R1 erased word bank0");
    rdc(ad(1, 11'h01F), 16'hFFFF, "R1 erased word bank1");

    prog(ad(0, 11'h003), 16'h1234);
    chk("R2 busy after fourth write", {15'd0, busy}, 16'h0001);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R3 busy length", 16'(n), 16'(PROG_CYC));
    rdc(ad(0, 11'h003), 16'h1234, "R2 programmed word");

    prog(ad(0, 11'h005), 16'h0080);
    rdc(ad(0, 11'h005), 16'h0000, "R5 first status read");
    rdc(ad(0, 11'h005), 16'h0040, "R5 second status toggles");
    rdc(ad(1, 11'h007), 16'hFFFF, "R5 other bank array");
    wr(ad(0, 11'h000), 16'h00F0);
    prog(ad(1, 11'h007), 16'h0000);
    chk("R3 still busy after ignored writes", {15'd0, busy}, 16'h0001);
    wait_idle();
    rdc(ad(0, 11'h005), 16'h0080, "R3 program survives reset write");
    rdc(ad(1, 11'h007), 16'hFFFF, "R3 sequence during busy ignored");

    prog(ad(0, 11'h003), 16'h00FF);
    wait_idle();
    rdc(ad(0, 11'h003), 16'h0020, "R4 error status");
    rdc(ad(0, 11'h003), 16'h0060, "R4 error status toggles");
    prog(ad(0, 11'h008), 16'h0000);
    chk("R10 program refused in error bank", {15'd0, busy}, 16'h0000);
    wr(ad(0, 11'h000), 16'h00F0);
    rdc(ad(0, 11'h003), 16'h0034, "R4 merged value after reset");

    wr(ad(0, 11'h555), 16'h00AA);
    wr(ad(0, 11'h100), 16'h00F0);
    wr(ad(0, 11'h2AA), 16'h0055);
    wr(ad(0, 11'h555), 16'h00A0);
    wr(ad(0, 11'h009), 16'h0000);
    chk("R6 abort after first unlock busy", {15'd0, busy}, 16'h0000);
    rdc(ad(0, 11'h009), 16'hFFFF, "R6 abort after first unlock");
    unlock(0);
    wr(ad(0, 11'h555), 16'h00F0);
    wr(ad(0, 11'h555), 16'h00A0);
    wr(ad(0, 11'h009), 16'h0000);
    rdc(ad(0, 11'h009), 16'hFFFF, "R6 abort after second unlock");

    prog(ad(1, 11'h010), 16'hFFF0);
    chk("R7 F0 taken as data", {15'd0, busy}, 16'h0001);
    wait_idle();
    rdc(ad(1, 11'h010), 16'hFFF0, "R7 stored F0 data");

    wr(ad(0, 11'h555), 16'h00AA);
    wr(ad(0, 11'h123), 16'h0055);
    wr(ad(0, 11'h555), 16'h00A0);
    wr(ad(0, 11'h00A), 16'h0000);
    rdc(ad(0, 11'h00A), 16'hFFFF, "R8 wrong unlock address");
    unlock(0);
    wr(ad(0, 11'h555), 16'h0080);
    wr(ad(0, 11'h00A), 16'h0000);
    rdc(ad(0, 11'h00A), 16'hFFFF, "R8 unknown command");

    unlock(1);
    wr(ad(1, 11'h555), 16'h0090);
    rdc(ad(1, 11'h000), 16'h0001, "R9 maker code");
    rdc(ad(1, 11'h001), 16'h227E, "R9 id word 1");
    rdc(ad(1, 11'h00E), 16'h2204, "R9 id word 2");
    rdc(ad(1, 11'h00F), 16'h2201, "R9 id word 3");
    rdc(ad(1, 11'h002), 16'h0001, "R9 locked sector");
    rdc(ad(1, 11'h012), 16'h0000, "R9 unlocked sector");
    rdc(ad(1, 11'h000), 16'h0001, "R9 repeat read");
    rdc(ad(0, 11'h003), 16'h0034, "R11 other bank array");
    prog(ad(1, 11'h005), 16'h0000);
    chk("R11 program refused in autoselect", {15'd0, busy}, 16'h0000);
    wr(ad(1, 11'h000), 16'h00FF);
    rdc(ad(1, 11'h000), 16'h0001, "R11 still autoselect");
    wr(ad(1, 11'h000), 16'h00F0);
    rdc(ad(1, 11'h000), 16'hFFFF, "R11 reset to read");
    rdc(ad(1, 11'h005), 16'hFFFF, "R11 refused program left no trace");

    erase_act = 2'b01;
    unlock(1);
    wr(ad(1, 11'h555), 16'h0090);
    rdc(ad(1, 11'h000), 16'hFFFF, "R10 autoselect refused while erasing");
    prog(ad(1, 11'h004), 16'h0000);
    chk("R10 program refused while erasing", {15'd0, busy}, 16'h0000);
    erase_act = 2'b00;

    prog(ad(1, 11'h01F), 16'hA5A5); wait_idle();
    prog(ad(1, 11'h000), 16'h0F0F); wait_idle();
    prog(ad(0, 11'h01F), 16'h1111); wait_idle();
    rdc(ad(1, 11'h01F), 16'hA5A5, "R12 bank1 high sector");
    rdc(ad(1, 11'h000), 16'h0F0F, "R12 bank1 low sector");
    rdc(ad(0, 11'h01F), 16'h1111, "R12 bank0 high sector");
    rdc(ad(0, 11'h003), 16'h0034, "R12 earlier word intact");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule